// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block carries out the stack work behind four control transfers: a near subroutine call, its return, entry into an interrupt handler and the return from that handler. It holds the instruction pointer, code segment, flags word and stack pointer. It moves 16-bit words between these registers and a word-wide stack memory that sits outside the block. The memory sees a byte address and drops the lowest bit.

A transfer begins with a one-cycle start strobe together with a one-hot command. The caller also supplies the address of the next instruction, plus either a call target or an interrupt vector (segment and offset). The block then goes through a fixed series of states, one stack access per state. It raises `done` for a single cycle when the last access has been made. Return points are saved and restored in last-in-first-out order, so calls and interrupts can nest to any depth the memory allows.

Top module: `stack_seq`

## Requirements
- R1: After reset, ip, cs, flags and sp hold their reset parameters (all 0 by default), and done and busy are low.
- R2: Command bit 0 (call): sp drops by 2, next_ip is written at the new sp, ip takes call_tgt. cs and flags are unchanged.
- R3: Command bit 1 (return): ip is loaded from the word at sp, then sp rises by 2. cs and flags are unchanged.
- R4: Command bit 2 (interrupt): three words are pushed, each after sp drops by 2, in the order flags, old cs, next_ip. cs:ip then take vec_cs:vec_ip, and flags is unchanged.
- R5: Command bit 3 (interrupt return): three words are popped, each followed by sp rising by 2, in the order ip, cs, flags.
- R6: Each state makes exactly one stack access. done is high for exactly one cycle, on the cycle after the last access: 1 access for call and return, 3 for interrupt and interrupt return.
- R7: A start strobe that arrives while busy is high has no effect on the running sequence or on the results.
- R8: A start strobe with a command that is not one-hot starts nothing: no stack access, no done, and no register change.
- R9: sp arithmetic wraps modulo 2^16. A push from sp=0 writes at 0xFFFE, and a pop at 0xFFFE leaves sp=0.
- R10: A nested call, interrupt, interrupt return and return restores ip, cs, flags and sp to their values before the call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| cmd | input | 4 | One-hot command: [0] call, [1] return, [2] interrupt, [3] interrupt return |
| next_ip | input | 16 | Address of the next instruction, saved by call and interrupt |
| call_tgt | input | 16 | Target offset of a call |
| vec_cs | input | 16 | Interrupt vector segment |
| vec_ip | input | 16 | Interrupt vector offset |
| mem_addr | output | 16 | Byte address of the stack access |
| mem_we | output | 1 | Stack write enable |
| mem_re | output | 1 | Stack read strobe |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read at mem_addr, same cycle |
| ip | output | 16 | Instruction pointer |
| cs | output | 16 | Code segment |
| flags | output | 16 | Flags word |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The rising edge that accepts a start strobe is edge 0. The last access happens on edge n, where n is 1 for call and return and 3 for interrupt and interrupt return. done and the updated registers appear after edge n, and done is low again after edge n+1. The bench drives inputs at falling edges and samples at falling edges. It checks that done is low after edges 0 to n-1, checks done and every register after edge n, and checks that done and busy have dropped after edge n+1. Pushed words are compared in the bench memory once the sequence has finished.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int          W      = 16,
  parameter logic [15:0] RST_IP = 16'h0000,
  parameter logic [15:0] RST_CS = 16'h0000,
  parameter logic [15:0] RST_FL = 16'h0000,
  parameter logic [15:0] RST_SP = 16'h0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   cmd,
  input  logic [W-1:0] next_ip,
  input  logic [W-1:0] call_tgt,
  input  logic [W-1:0] vec_cs,
  input  logic [W-1:0] vec_ip,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic         mem_re,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] ip,
  output logic [W-1:0] cs,
  output logic [W-1:0] flags,
  output logic [W-1:0] sp,
  output logic         busy,
  output logic         done
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  typedef enum logic [3:0] {
    S_IDLE, S_CALL, S_RET, S_INT_F, S_INT_C, S_INT_I, S_IRET_I, S_IRET_C, S_IRET_F
  } st_t;

  st_t state;
  logic [W-1:0] nip_h, tgt_h, vcs_h;

  wire cmd_ok = (cmd != 4'd0) && ((cmd & (cmd - 4'd1)) == 4'd0);
  wire push   = (state == S_CALL) || (state == S_INT_F) || (state == S_INT_C) || (state == S_INT_I);

  assign busy     = (state != S_IDLE);
  assign mem_we   = push;
  assign mem_re   = busy && !push;
  assign mem_addr = push ? sp - STEP : sp;

  always_comb begin
    case (state)
      S_INT_F: mem_wdata = flags;
      S_INT_C: mem_wdata = cs;
      default: mem_wdata = nip_h;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ip    <= RST_IP;
      cs    <= RST_CS;
      flags <= RST_FL;
      sp    <= RST_SP;
      nip_h <= '0;
      tgt_h <= '0;
      vcs_h <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start && cmd_ok) begin
          nip_h <= next_ip;
          tgt_h <= cmd[0] ? call_tgt : vec_ip;
          vcs_h <= vec_cs;
          if (cmd[0])      state <= S_CALL;
          else if (cmd[1]) state <= S_RET;
          else if (cmd[2]) state <= S_INT_F;
          else             state <= S_IRET_I;
        end
        S_CALL: begin
          sp    <= sp - STEP;
          ip    <= tgt_h;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_RET: begin
          ip    <= mem_rdata;
          sp    <= sp + STEP;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_INT_F: begin
          sp    <= sp - STEP;
          state <= S_INT_C;
        end
        S_INT_C: begin
          sp    <= sp - STEP;
          state <= S_INT_I;
        end
        S_INT_I: begin
          sp    <= sp - STEP;
          cs    <= vcs_h;
          ip    <= tgt_h;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        S_IRET_I: begin
          ip    <= mem_rdata;
          sp    <= sp + STEP;
          state <= S_IRET_C;
        end
        S_IRET_C: begin
          cs    <= mem_rdata;
          sp    <= sp + STEP;
          state <= S_IRET_F;
        end
        S_IRET_F: begin
          flags <= mem_rdata;
          sp    <= sp + STEP;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_push_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == $past(sp) - STEP);

  assert_pop_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(sp) + STEP);

  assert_call_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CALL) |=> (ip == $past(tgt_h) && cs == $past(cs) && flags == $past(flags)));

  assert_vector_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INT_I) |=> (cs == $past(vcs_h) && ip == $past(tgt_h) && flags == $past(flags)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && cmd_ok)) |=> (!busy && !done && $stable(sp) && $stable(ip)));

  assert_one_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/stack_seq_tb.sv
module stack_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [15:0] next_ip = '0, call_tgt = '0, vec_cs = '0, vec_ip = '0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, ip, cs, flags, sp;
  logic mem_we, mem_re, busy, done;

  always #5 clk = ~clk;

  stack_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .next_ip(next_ip),
    .call_tgt(call_tgt), .vec_cs(vec_cs), .vec_ip(vec_ip), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ip(ip), .cs(cs), .flags(flags), .sp(sp), .busy(busy), .done(done)
  );

  logic [15:0] smem [512];
  logic [15:0] mmem [512];
  assign mem_rdata = smem[mem_addr[9:1]];
  always @(posedge clk) if (mem_we) smem[mem_addr[9:1]] <= mem_wdata;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_ip, m_cs, m_fl, m_sp;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [8:0] wi(input logic [15:0] a);
    return a[9:1];
  endfunction

  task automatic model(input logic [3:0] c, input logic [15:0] nip, tgt, vcs, vip);
    if (c == 4'b0001) begin
      m_sp -= 16'd2; mmem[wi(m_sp)] = nip; m_ip = tgt;
    end else if (c == 4'b0010) begin
      m_ip = mmem[wi(m_sp)]; m_sp += 16'd2;
    end else if (c == 4'b0100) begin
      m_sp -= 16'd2; mmem[wi(m_sp)] = m_fl;
      m_sp -= 16'd2; mmem[wi(m_sp)] = m_cs;
      m_sp -= 16'd2; mmem[wi(m_sp)] = nip;
      m_cs = vcs; m_ip = vip;
    end else if (c == 4'b1000) begin
      m_ip = mmem[wi(m_sp)]; m_sp += 16'd2;
      m_cs = mmem[wi(m_sp)]; m_sp += 16'd2;
      m_fl = mmem[wi(m_sp)]; m_sp += 16'd2;
    end
  endtask

  task automatic check_regs(input string req);
    chk({req, " ip"}, ip, m_ip);
    chk({req, " cs"}, cs, m_cs);
    chk({req, " flags"}, flags, m_fl);
    chk({req, " sp"}, sp, m_sp);
  endtask

  // Runs one command; inj drives a second strobe while busy (R7).
  task automatic run_op(input string req, input logic [3:0] c, input logic [15:0] nip, tgt,
                        vcs, vip, input bit inj);
    int n;
    n = (c == 4'b0100 || c == 4'b1000) ? 3 : 1;
    @(negedge clk);
    start = 1'b1; cmd = c; next_ip = nip; call_tgt = tgt; vec_cs = vcs; vec_ip = vip;
    model(c, nip, tgt, vcs, vip);
    @(posedge clk);
    @(negedge clk);
    start = inj; cmd = inj ? 4'b0001 : 4'd0;
    call_tgt = inj ? ~tgt : tgt; next_ip = inj ? ~nip : nip;
    chk({req, " R6 done early"}, {15'd0, done}, 16'd0);
    for (int k = 1; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; cmd = 4'd0;
      chk({req, " R6 done early"}, {15'd0, done}, 16'd0);
    end
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; cmd = 4'd0;
    chk({req, " R6 done due"}, {15'd0, done}, 16'd1);
    check_regs(req);
    if (c == 4'b0001 || c == 4'b0100)
      for (int k = 0; k < n; k++)
        chk({req, " pushed word"}, smem[wi(m_sp + 16'(2 * k))], mmem[wi(m_sp + 16'(2 * k))]);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R6 done single"}, {15'd0, done}, 16'd0);
    chk({req, " R7 idle after"}, {15'd0, busy}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] s_ip, s_cs, s_fl, s_sp;
    for (int i = 0; i < 512; i++) begin smem[i] = '0; mmem[i] = '0; end
    m_ip = 0; m_cs = 0; m_fl = 0; m_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_regs("R1 reset");
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 busy", {15'd0, busy}, 16'd0);

    // R9: push from sp=0 lands at 0xFFFE, then pop wraps back to 0
    run_op("R2 R9 wrap call", 4'b0001, 16'h1234, 16'h0040, 16'h0, 16'h0, 1'b0);
    chk("R9 wrap sp", sp, 16'hFFFE);
    chk("R9 wrap slot", smem[9'h1FF], 16'h1234);
    run_op("R3 R9 wrap ret", 4'b0010, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
    chk("R9 wrap back", sp, 16'h0000);
    chk("R3 ret ip", ip, 16'h1234);

    @(negedge clk);
    smem[0] = 16'h0100; smem[1] = 16'h2000; smem[2] = 16'h0A55;
    mmem[0] = 16'h0100; mmem[1] = 16'h2000; mmem[2] = 16'h0A55;
    run_op("R5 iret preload", 4'b1000, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
    chk("R5 order ip", ip, 16'h0100);
    chk("R5 order cs", cs, 16'h2000);
    chk("R5 order flags", flags, 16'h0A55);

    // R8: non-one-hot command
    @(negedge clk);
    start = 1'b1; cmd = 4'b0011; call_tgt = 16'hDEAD; next_ip = 16'hBEEF;
    @(negedge clk);
    start = 1'b0; cmd = 4'd0;
    repeat (4) begin
      @(negedge clk);
      chk("R8 no done", {15'd0, done}, 16'd0);
    end
    check_regs("R8 unchanged");

    // R10: nested call, interrupt, iret, ret
    s_ip = m_ip; s_cs = m_cs; s_fl = m_fl; s_sp = m_sp;
    run_op("R2 nest call", 4'b0001, s_ip, 16'h0400, 16'h0, 16'h0, 1'b0);
    run_op("R4 nest int", 4'b0100, 16'h0405, 16'h0, 16'h3000, 16'h0010, 1'b1);
    chk("R4 push order flags", smem[wi(sp + 16'd4)], 16'h0A55);
    chk("R4 push order cs", smem[wi(sp + 16'd2)], 16'h2000);
    chk("R4 push order ip", smem[wi(sp)], 16'h0405);
    chk("R7 vector kept", ip, 16'h0010);
    run_op("R5 nest iret", 4'b1000, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
    chk("R10 iret ip", ip, 16'h0405);
    run_op("R3 nest ret", 4'b0010, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
    chk("R10 ip", ip, s_ip);
    chk("R10 cs", cs, s_cs);
    chk("R10 flags", flags, s_fl);
    chk("R10 sp", sp, s_sp);

    // Random mix against the model
    void'($urandom(32'd7531));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] c;
      c = 4'b0001 << ($urandom % 4);
      run_op("R2 R3 R4 R5 R7 random", c, 16'($urandom), 16'($urandom), 16'($urandom),
             16'($urandom), ($urandom % 5) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule